// File: doc/BRIEF.md
# Priority Reference Source Selector

This block chooses which of three grouped timing references drives a downstream clock loop: a master (index 0), a slave (index 1) and a stand-by (index 2). Each input arrives with a validity flag from an external monitor. A priority table, written by configuration software, ranks the inputs. The block publishes a registered source index, a holdover flag for when no input can be used, and a one-cycle pulse each time the selection changes.

There are three ways to make the choice, and a fixed precedence sets which one applies. A configuration register force wins over everything else. Below it, an external fast-switch pin picks between master and slave. When neither is active, an automatic scan picks the best qualified input from the table. Whenever validity or configuration changes, the result follows on the next clock, so the block leaves holdover as soon as a usable input returns.

Top module: `refsel_top`

## Requirements
- R1: In automatic mode (`cfgForceEn`=0, `pinFastEn`=0), the block selects the valid input whose priority field has the smallest non-zero value; 1 is the highest rank. Input i's 4-bit field sits at `prioTable[4*i+3:4*i]`, and bit i of `srcValid` marks input i as valid.
- R2: If two or more qualified inputs share the best priority value, the lowest input index wins.
- R3: A priority field of 0 excludes that input from automatic selection, even when its validity bit is set.
- R4: In automatic mode with no qualified input, `holdover` goes to 1 and `selIdx` keeps the index it held last.
- R5: Selection is re-evaluated every cycle. When the selected input is disqualified, the block moves to the next best qualified input. When it is in holdover and a qualified input appears, it leaves holdover on the next clock.
- R6: With `cfgForceEn`=1, a `cfgForceSel` value of 0, 1 or 2 selects that input whatever its validity or priority. A value of 3 forces holdover. This register force also overrides the pin.
- R7: With `pinFastEn`=1 and no register force, the block ignores the priority table. It selects the input named by `pinSlave` (0 = master, 1 = slave) if that input is valid. Otherwise it takes the other member of the pair if valid, then the stand-by if valid, and otherwise it enters holdover.
- R8: `selChange` is high for exactly one cycle, the same cycle in which `selIdx` or `holdover` first shows a new value. Re-entering selection of the same index after holdover counts as a change. While `holdover` stays 1, `selIdx` has no effect on `selChange`.
- R9: All outputs are registered. Inputs sampled at one rising edge determine the outputs seen after that same edge.
- R10: While `rstN` is low, `selIdx`=0, `holdover`=1 and `selChange`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | 3 | Per-input validity flags from the monitors |
| prioTable | input | 12 | Three 4-bit priority fields, one per input; 0 excludes the input |
| cfgForceEn | input | 1 | Enables the register force |
| cfgForceSel | input | 2 | Forced input index; 3 forces holdover |
| pinFastEn | input | 1 | Enables the external master/slave fast switch |
| pinSlave | input | 1 | Fast-switch choice: 0 master, 1 slave |
| selIdx | output | 2 | Selected input index |
| holdover | output | 1 | No input selected; downstream loop should hold |
| selChange | output | 1 | One-cycle pulse when the selection or holdover state changes |

## Verification
A wrong internal state reaches the ports within one clock, because `selIdx` and `holdover` are recomputed and registered every cycle. A faulty rank comparison, tie rule or exclusion therefore shows up as a wrong index on the cycle after the stimulus. A broken change detector shows up as a missing or stray `selChange` pulse on the same cycle as the output transition. The bench compares every cycle against a behavioural model. It drives directed cases for each mode, then long random runs in which ties and excluded entries are frequent.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int REF_COUNT = 3;
  localparam int IDX_W = $clog2(REF_COUNT + 1);
  localparam int MASTER_IDX = 0;
  localparam int SLAVE_IDX = 1;
  localparam int STANDBY_IDX = 2;

  typedef struct packed {
    logic             holdStb;
    logic             loadStb;
    logic [IDX_W-1:0] idx;
  } selStrobe_t;
endpackage

// File: rtl/refsel_scan.sv
module refsel_scan #(
  parameter int NUM = 3,
  parameter int PW = 4,
  localparam int IW = $clog2(NUM + 1)
) (
  input  logic [NUM-1:0]    valid,
  input  logic [NUM*PW-1:0] prio,
  output logic              anyOk,
  output logic [IW-1:0]     bestIdx
);
  logic [PW-1:0] bestPrio;

  always_comb begin
    anyOk = 1'b0;
    bestIdx = '0;
    bestPrio = '1;
    for (int i = 0; i < NUM; i++) begin
      if (valid[i] && (prio[i*PW +: PW] != '0) &&
          (!anyOk || (prio[i*PW +: PW] < bestPrio))) begin
        anyOk = 1'b1;
        bestIdx = IW'(i);
        bestPrio = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REF_COUNT-1:0] srcValid,
  input  logic                 cfgForceEn,
  input  logic [IDX_W-1:0]     cfgForceSel,
  input  logic                 pinFastEn,
  input  logic                 pinSlave,
  input  logic                 autoOk,
  input  logic [IDX_W-1:0]     autoIdx,
  output selStrobe_t           strobe
);
  logic             prefValid;
  logic             otherValid;
  logic [IDX_W-1:0] prefIdx;
  logic [IDX_W-1:0] otherIdx;

  assign prefIdx = pinSlave ? IDX_W'(SLAVE_IDX) : IDX_W'(MASTER_IDX);
  assign otherIdx = pinSlave ? IDX_W'(MASTER_IDX) : IDX_W'(SLAVE_IDX);
  assign prefValid = srcValid[prefIdx];
  assign otherValid = srcValid[otherIdx];

  always_comb begin
    strobe = '0;
    if (cfgForceEn) begin
      if (cfgForceSel < IDX_W'(REF_COUNT)) begin
        strobe.loadStb = 1'b1;
        strobe.idx = cfgForceSel;
      end else begin
        strobe.holdStb = 1'b1;
      end
    end else if (pinFastEn) begin
      if (prefValid) begin
        strobe.loadStb = 1'b1;
        strobe.idx = prefIdx;
      end else if (otherValid) begin
        strobe.loadStb = 1'b1;
        strobe.idx = otherIdx;
      end else if (srcValid[STANDBY_IDX]) begin
        strobe.loadStb = 1'b1;
        strobe.idx = IDX_W'(STANDBY_IDX);
      end else begin
        strobe.holdStb = 1'b1;
      end
    end else if (autoOk) begin
      strobe.loadStb = 1'b1;
      strobe.idx = autoIdx;
    end else begin
      strobe.holdStb = 1'b1;
    end
  end

  // R5: every cycle carries exactly one decision, so selection is always re-evaluated
  assert_one_decision_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.holdStb, strobe.loadStb}) == 1);

  // R7: with the pin active and no valid input at all, only holdover may be requested
  assert_pin_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgForceEn && pinFastEn && (srcValid == '0)) |-> strobe.holdStb);
endmodule

// File: rtl/refsel_dp.sv
module refsel_dp
  import refsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  selStrobe_t       strobe,
  output logic [IDX_W-1:0] selIdx,
  output logic             holdover,
  output logic             selChange
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx <= '0;
      holdover <= 1'b1;
      selChange <= 1'b0;
    end else begin
      selChange <= (strobe.holdStb && !holdover) ||
                   (strobe.loadStb && (holdover || (strobe.idx != selIdx)));
      if (strobe.holdStb) begin
        holdover <= 1'b1;
      end else if (strobe.loadStb) begin
        holdover <= 1'b0;
        selIdx <= strobe.idx;
      end
    end
  end

  // R8: no pulse while the published selection is unchanged
  assert_pulse_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(selIdx) && $stable(holdover)) |-> !selChange);

  // R8: a change of holdover state always raises the pulse
  assert_pulse_on_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (holdover != $past(holdover)) |-> selChange);

  // R4: the index is frozen while holdover persists
  assert_hold_keeps_idx_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(holdover) && holdover) |-> $stable(selIdx));

  // R6: the published index always names a real input
  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    selIdx < IDX_W'(REF_COUNT));
endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int PRIO_W = 4,
  localparam int TBL_W = REF_COUNT * PRIO_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REF_COUNT-1:0] srcValid,
  input  logic [TBL_W-1:0]     prioTable,
  input  logic                 cfgForceEn,
  input  logic [IDX_W-1:0]     cfgForceSel,
  input  logic                 pinFastEn,
  input  logic                 pinSlave,
  output logic [IDX_W-1:0]     selIdx,
  output logic                 holdover,
  output logic                 selChange
);
  logic             autoOk;
  logic [IDX_W-1:0] autoIdx;
  selStrobe_t       strobe;

  refsel_scan #(.NUM(REF_COUNT), .PW(PRIO_W)) scan_i (
    .valid(srcValid), .prio(prioTable), .anyOk(autoOk), .bestIdx(autoIdx)
  );

  refsel_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .cfgForceEn(cfgForceEn),
    .cfgForceSel(cfgForceSel), .pinFastEn(pinFastEn), .pinSlave(pinSlave),
    .autoOk(autoOk), .autoIdx(autoIdx), .strobe(strobe)
  );

  refsel_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selIdx(selIdx),
    .holdover(holdover), .selChange(selChange)
  );

  // R4: automatic mode with nothing valid ends in holdover
  assert_none_valid_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgForceEn && !pinFastEn && (srcValid == '0)) |=> holdover);

  // R6: a register force of a real index is obeyed on the next cycle
  assert_force_src_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgForceEn && (cfgForceSel != 2'd3)) |=> (!holdover && (selIdx == $past(cfgForceSel))));

  // R7: a valid master chosen by the pin is selected on the next cycle
  assert_pin_master_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgForceEn && pinFastEn && !pinSlave && srcValid[0]) |=> (!holdover && (selIdx == 2'd0)));
endmodule

// File: tb/refsel_top_tb_top.sv
module refsel_top_tb_top;
  localparam time CLK_T = 20ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  srcValid = '0;
  logic [11:0] prioTable = '0;
  logic        cfgForceEn = 1'b0;
  logic [1:0]  cfgForceSel = '0;
  logic        pinFastEn = 1'b0;
  logic        pinSlave = 1'b0;
  logic [1:0]  selIdx;
  logic        holdover;
  logic        selChange;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;
  int  expSel = 0;
  bit  expHold = 1'b1;
  bit  expChg = 1'b0;
  string tag = "R10";

  always #(CLK_T / 2) clk = ~clk;

  refsel_top dut_i (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .prioTable(prioTable),
    .cfgForceEn(cfgForceEn), .cfgForceSel(cfgForceSel), .pinFastEn(pinFastEn),
    .pinSlave(pinSlave), .selIdx(selIdx), .holdover(holdover), .selChange(selChange)
  );

  task automatic modelStep();
    int  nSel = expSel;
    bit  nHold = 1'b0;
    if (cfgForceEn) begin
      if (cfgForceSel != 2'd3) nSel = cfgForceSel;
      else nHold = 1'b1;
    end else if (pinFastEn) begin
      int pref = pinSlave ? 1 : 0;
      int oth = pinSlave ? 0 : 1;
      if (srcValid[pref]) nSel = pref;
      else if (srcValid[oth]) nSel = oth;
      else if (srcValid[2]) nSel = 2;
      else nHold = 1'b1;
    end else begin
      int best = -1;
      int bestP = 1000;
      for (int i = 0; i < 3; i++) begin
        int p = int'(prioTable[i*4 +: 4]);
        if (srcValid[i] && p != 0 && p < bestP) begin
          best = i;
          bestP = p;
        end
      end
      if (best < 0) nHold = 1'b1;
      else nSel = best;
    end
    expChg = (nHold != expHold) || (!nHold && nSel != expSel);
    expHold = nHold;
    expSel = nSel;
  endtask

  task automatic compareOut();
    nRun++;
    if (int'(selIdx) != expSel || holdover != expHold) begin
      nFail++;
      $display("FAIL %s: selIdx=%0d holdover=%0b expected selIdx=%0d holdover=%0b",
               tag, selIdx, holdover, expSel, expHold);
    end
    nRun++;
    if (selChange != expChg) begin
      nFail++;
      $display("FAIL R8 (%s): selChange=%0b expected %0b", tag, selChange, expChg);
    end
  endtask

  task automatic cyc(input logic [2:0] v, input logic [11:0] pt, input logic fEn,
                     input logic [1:0] fSel, input logic pEn, input logic pSlv);
    @(negedge clk);
    compareOut();
    srcValid = v;
    prioTable = pt;
    cfgForceEn = fEn;
    cfgForceSel = fSel;
    pinFastEn = pEn;
    pinSlave = pSlv;
    modelStep();
  endtask

  task automatic autoCyc(input logic [2:0] v, input logic [11:0] pt);
    cyc(v, pt, 1'b0, 2'd0, 1'b0, 1'b0);
  endtask

  initial begin
    // R10: reset values, with inputs that would otherwise select something
    srcValid = 3'b111;
    prioTable = 12'h321;
    repeat (3) @(posedge clk);
    @(negedge clk);
    nRun++;
    if (selIdx != 2'd0 || holdover != 1'b1 || selChange != 1'b0) begin
      nFail++;
      $display("FAIL R10: sel=%0d hold=%0b chg=%0b expected 0 1 0", selIdx, holdover, selChange);
    end
    rstN = 1'b1;
    modelStep();

    // R1: smallest non-zero value wins
    tag = "R1";
    autoCyc(3'b111, 12'h321);
    autoCyc(3'b110, 12'h321);
    autoCyc(3'b110, 12'h123);
    autoCyc(3'b111, 12'h123);
    // R2: ties go to the lower index
    tag = "R2";
    autoCyc(3'b111, 12'h222);
    autoCyc(3'b110, 12'h222);
    autoCyc(3'b101, 12'h255);
    // R3: zero priority excludes a valid input
    tag = "R3";
    autoCyc(3'b110, 12'h001);
    autoCyc(3'b111, 12'h102);
    autoCyc(3'b111, 12'h000);
    // R4: nothing valid, index kept
    tag = "R4";
    autoCyc(3'b011, 12'h321);
    autoCyc(3'b000, 12'h321);
    autoCyc(3'b000, 12'h321);
    // R5: reacquire and fall through to next best
    tag = "R5";
    autoCyc(3'b100, 12'h321);
    autoCyc(3'b111, 12'h321);
    autoCyc(3'b110, 12'h321);
    autoCyc(3'b100, 12'h321);
    autoCyc(3'b000, 12'h321);
    autoCyc(3'b100, 12'h321);
    autoCyc(3'b100, 12'h321);
    // R6: register force, including over the pin
    tag = "R6";
    cyc(3'b000, 12'h321, 1'b1, 2'd1, 1'b0, 1'b0);
    cyc(3'b111, 12'h321, 1'b1, 2'd2, 1'b0, 1'b0);
    cyc(3'b111, 12'h321, 1'b1, 2'd3, 1'b0, 1'b0);
    cyc(3'b111, 12'h321, 1'b1, 2'd2, 1'b1, 1'b0);
    cyc(3'b001, 12'h000, 1'b1, 2'd0, 1'b1, 1'b1);
    // R7: fast-switch pin fallback chain, priorities ignored
    tag = "R7";
    cyc(3'b011, 12'h000, 1'b0, 2'd0, 1'b1, 1'b1);
    cyc(3'b011, 12'h000, 1'b0, 2'd0, 1'b1, 1'b0);
    cyc(3'b101, 12'h111, 1'b0, 2'd0, 1'b1, 1'b1);
    cyc(3'b100, 12'h111, 1'b0, 2'd0, 1'b1, 1'b0);
    cyc(3'b000, 12'h111, 1'b0, 2'd0, 1'b1, 1'b0);
    cyc(3'b010, 12'h111, 1'b0, 2'd0, 1'b1, 1'b0);
    // R9: random traffic, one-cycle latency
    tag = "R9";
    for (int k = 0; k < 3000; k++) begin
      logic [2:0]  v = 3'($urandom);
      logic [11:0] pt;
      for (int i = 0; i < 3; i++) pt[i*4 +: 4] = 4'($urandom_range(0, 3));
      cyc(v, pt, ($urandom_range(0, 9) == 0), 2'($urandom),
          ($urandom_range(0, 3) == 0), 1'($urandom));
    end
    autoCyc(3'b000, 12'h000);
    @(negedge clk);
    compareOut();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_T * 100000);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule